// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Request Arbitration

This block sits between a single request port and a simplified DRAM command port. A free-running interval timer raises a tick once per refresh interval, and each tick adds one to a count of owed refreshes. When refreshes are owed, the block issues an auto-refresh command ahead of any ordinary read or write request. After a refresh command goes out, the command port stays quiet for a fixed refresh cycle time, and no part of that window can be cut short.

Urgent requests, such as DMA traffic, may postpone owed refreshes, but only while fewer than `DEFER_LIMIT` are outstanding. Once the owed count reaches that limit, the block enters a catch-up mode. In this mode it issues refreshes back to back, one per window, until nothing is owed. All requests are blocked while catch-up runs. A sticky error flag reports when the owed count would exceed `DEFER_LIMIT + 1`, which means the refresh budget cannot be met.

The controller has three states. `ST_IDLE` serves requests or starts a refresh. `ST_WINDOW` holds an ordinary refresh window. `ST_CATCHUP` holds a forced burst. The transitions are:
- `ST_IDLE` goes to `ST_WINDOW` when a refresh is issued while fewer than `DEFER_LIMIT` are owed.
- `ST_IDLE` goes to `ST_CATCHUP` when a refresh is issued with `DEFER_LIMIT` or more owed.
- `ST_WINDOW` goes to `ST_IDLE` on the last cycle of the window.
- `ST_CATCHUP` issues the next refresh when its window counter reaches zero.
- `ST_CATCHUP` goes to `ST_IDLE` on the last cycle of a window, provided nothing is owed and no tick arrives in that cycle.

Top module: `refresh_sched`

## Requirements
- R1: The interval timer ticks on cycle `REF_INTERVAL-1` after reset and then every `REF_INTERVAL` cycles, whatever the state. Each tick adds one owed refresh, each issued refresh removes one, and a tick in the same cycle as an issue leaves the count unchanged. With no requests, the first refresh command appears on cycle `REF_INTERVAL`.
- R2: In `ST_IDLE` with at least one refresh owed and no deferral allowed, the block issues `cmd_valid`=1 with `cmd_kind`=2'b10 (refresh) and holds `req_ready` low. A concurrent request is stalled.
- R3: After any refresh command, `cmd_valid` and `req_ready` stay low for the next `REF_WINDOW-1` cycles. The earliest next command comes `REF_WINDOW` cycles after the refresh.
- R4: In `ST_IDLE`, when owed refreshes number between 1 and `DEFER_LIMIT-1` and a request is valid with `req_urgent`=1, the request is served and the refresh is postponed. A non-urgent request never postpones a refresh.
- R5: A refresh issued from `ST_IDLE` with `DEFER_LIMIT` or more owed starts catch-up. Further refreshes then follow every `REF_WINDOW` cycles until the count is zero, and `req_ready` stays low throughout.
- R6: In `ST_IDLE` with nothing owed, `req_ready` is 1. An accepted request (`req_valid` and `req_ready` both 1) drives `cmd_valid`=1 in the same cycle, with `cmd_kind` set to 2'b01 for a write or 2'b00 for a read. When `cmd_valid` is 0, `cmd_kind` reads 2'b00.
- R7: After reset, `req_ready`=1, `cmd_valid`=0 and `err_overflow`=0.
- R8: `err_overflow` sets when a tick arrives with `DEFER_LIMIT+1` owed and no refresh is issued in that cycle. The owed count then stays at `DEFER_LIMIT+1`, and the flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_urgent | input | 1 | Request may postpone a refresh |
| req_write | input | 1 | 1 for write, 0 for read |
| req_ready | output | 1 | Request accepted this cycle when valid |
| cmd_valid | output | 1 | Command strobe |
| cmd_kind | output | 2 | 00 read, 01 write, 10 refresh |
| err_overflow | output | 1 | Sticky refresh budget overflow |

## Verification
The scheduler is exercised with four input patterns:
- Isolated single requests show that ordinary service and the reset state are correct.
- A continuous non-urgent stream that crosses several ticks tells hard refresh priority and window stalling apart from any deferral.
- A continuous urgent stream shows that postponement accumulates up to the limit and then turns into a back-to-back catch-up burst.
- A pseudo-random mix of valid, urgent and write flags hits ticks landing inside windows and during deferral.

A second instance whose window is longer than its interval checks the sticky overflow flag.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WINDOW  = 2'd1,
        ST_CATCHUP = 2'd2
    } sched_state_t;

    typedef enum logic [1:0] {
        CMD_READ    = 2'b00,
        CMD_WRITE   = 2'b01,
        CMD_REFRESH = 2'b10
    } cmd_kind_t;
endpackage

// File: rtl/refsched_tick.sv
module refsched_tick #(
    parameter int REF_INTERVAL = 6250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
    localparam logic [TW-1:0] LAST = TW'(REF_INTERVAL - 1);

    logic [TW-1:0] count_q;

    assign tick = (count_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)    count_q <= '0;
        else if (tick) count_q <= '0;
        else           count_q <= count_q + 1'b1;
    end
endmodule

// File: rtl/refsched_owed.sv
module refsched_owed #(
    parameter int DEFER_LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic issue,
    output logic [$clog2(DEFER_LIMIT+2)-1:0] owed,
    output logic err
);
    localparam int OW = $clog2(DEFER_LIMIT + 2);
    localparam logic [OW-1:0] CEIL = OW'(DEFER_LIMIT + 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
            err  <= 1'b0;
        end else if (tick && !issue) begin
            if (owed == CEIL) err  <= 1'b1;
            else              owed <= owed + 1'b1;
        end else if (issue && !tick) begin
            owed <= owed - 1'b1;
        end
    end

    // R1: an issued refresh always consumes an owed one
    p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (owed != '0));
    // R1: tick and issue together cancel
    p_cancel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && issue) |=> $stable(owed));
    // R8: error flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R8: count never passes the ceiling
    p_ceiling_r8: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= CEIL);
endmodule

// File: rtl/refsched_window.sv
module refsched_window #(
    parameter int REF_WINDOW = 280
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic last,
    output logic zero
);
    localparam int WW = (REF_WINDOW > 2) ? $clog2(REF_WINDOW) : 1;
    localparam logic [WW-1:0] START = WW'(REF_WINDOW - 1);

    logic [WW-1:0] left_q;

    assign last = (left_q == WW'(1));
    assign zero = (left_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)     left_q <= '0;
        else if (load)  left_q <= START;
        else if (!zero) left_q <= left_q - 1'b1;
    end

    // R3: a load only happens once the previous window has fully drained
    p_load_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> zero);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refsched_pkg::*;
#(
    parameter int REF_INTERVAL = 6250,
    parameter int REF_WINDOW   = 280,
    parameter int DEFER_LIMIT  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_urgent,
    input  logic       req_write,
    output logic       req_ready,
    output logic       cmd_valid,
    output logic [1:0] cmd_kind,
    output logic       err_overflow
);
    localparam int OW = $clog2(DEFER_LIMIT + 2);
    localparam logic [OW-1:0] LIMIT = OW'(DEFER_LIMIT);

    sched_state_t  state_q, state_d;
    logic          tick, ref_go, win_last, win_zero, accepted;
    logic [OW-1:0] owed;

    refsched_tick #(.REF_INTERVAL(REF_INTERVAL)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    refsched_owed #(.DEFER_LIMIT(DEFER_LIMIT)) u_owed (
        .clk(clk), .rst_n(rst_n), .tick(tick), .issue(ref_go),
        .owed(owed), .err(err_overflow)
    );

    refsched_window #(.REF_WINDOW(REF_WINDOW)) u_win (
        .clk(clk), .rst_n(rst_n), .load(ref_go),
        .last(win_last), .zero(win_zero)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state, ready and refresh issue
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        ref_go    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (owed == '0) begin
                    req_ready = 1'b1;
                end else if (owed < LIMIT && req_valid && req_urgent) begin
                    req_ready = 1'b1;
                end else begin
                    ref_go  = 1'b1;
                    state_d = (owed >= LIMIT) ? ST_CATCHUP : ST_WINDOW;
                end
            end
            ST_WINDOW: begin
                if (win_last) state_d = ST_IDLE;
            end
            ST_CATCHUP: begin
                if (win_zero)                             ref_go  = 1'b1;
                else if (win_last && owed == '0 && !tick) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // command outputs
    always_comb begin
        accepted  = req_valid && req_ready;
        cmd_valid = ref_go || accepted;
        if (ref_go)                     cmd_kind = CMD_REFRESH;
        else if (accepted && req_write) cmd_kind = CMD_WRITE;
        else                            cmd_kind = CMD_READ;
    end

    // R2: owed refresh with a non-urgent request stalls that request
    p_ref_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && owed != '0 && req_valid && !req_urgent) |-> !req_ready);
    // R3: nothing follows a refresh command in the next cycle
    p_window_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_REFRESH) |=> !cmd_valid && !req_ready);
    // R5: catch-up blocks requests
    p_catchup_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CATCHUP) |-> !req_ready);
    // R6: accepted request yields a matching command
    p_grant_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |->
            cmd_valid && cmd_kind == (req_write ? CMD_WRITE : CMD_READ));
endmodule

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
    localparam int INTV = 40;
    localparam int WIN  = 6;
    localparam int LIM  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_urgent = 1'b0, req_write = 1'b0;
    logic req_ready, cmd_valid, err_overflow;
    logic [1:0] cmd_kind;
    logic r1_ready, r1_valid, r1_err;
    logic [1:0] r1_kind;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;

    always #4 clk = ~clk;

    refresh_sched #(.REF_INTERVAL(INTV), .REF_WINDOW(WIN), .DEFER_LIMIT(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_urgent(req_urgent),
        .req_write(req_write), .req_ready(req_ready), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .err_overflow(err_overflow)
    );

    // window longer than interval: refresh budget cannot be met
    refresh_sched #(.REF_INTERVAL(3), .REF_WINDOW(8), .DEFER_LIMIT(1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(1'b0), .req_urgent(1'b0),
        .req_write(1'b0), .req_ready(r1_ready), .cmd_valid(r1_valid),
        .cmd_kind(r1_kind), .err_overflow(r1_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: owed refreshes, mode, cycles left in window
    int m_tmr, m_owed, m_mode, m_left, cyc;
    int first_ref = -1, last_ref = -1000, last_cmd = -1000;
    int b2b = 0, gap_bad = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_tmr = 0; m_owed = 0; m_mode = 0; m_left = 0; cyc = 0;
        end else begin
            bit tk, e_rdy, e_ref, e_val;
            int e_kind;
            string tag;
            tk = (m_tmr == INTV - 1);
            e_rdy = 0; e_ref = 0;
            if (m_mode == 0) begin
                if (m_owed == 0) e_rdy = 1;
                else if (m_owed < LIM && req_valid && req_urgent) e_rdy = 1;
                else e_ref = 1;
            end else if (m_mode == 2 && m_left == 0) e_ref = 1;
            e_val  = e_ref || (req_valid && e_rdy);
            e_kind = e_ref ? 2 : (e_val && req_write) ? 1 : 0;
            if (m_mode == 2)                tag = "R5";
            else if (m_mode == 1)           tag = "R3";
            else if (e_ref)                 tag = "R2";
            else if (m_owed > 0 && e_rdy)   tag = "R4";
            else                            tag = "R6";
            if (model_on) begin
                check(req_ready == e_rdy, {tag, " ready"}, req_ready, e_rdy);
                check(cmd_valid == e_val, {tag, " cmd_valid"}, cmd_valid, e_val);
                check(cmd_kind == e_kind, {tag, " cmd_kind"}, cmd_kind, e_kind);
                check(err_overflow == 1'b0, "R8 no error", err_overflow, 0);
            end
            // observed timing statistics
            if (cmd_valid && cmd_kind == 2'b10) begin
                if (first_ref < 0) first_ref = cyc;
                if (cyc - last_ref == WIN) b2b++;
            end
            if (cmd_valid) begin
                if (cyc - last_ref < WIN) gap_bad++;
                if (cmd_kind == 2'b10) last_ref = cyc;
                last_cmd = cyc;
            end
            // model update
            if (m_mode == 0) begin
                if (e_ref) begin m_mode = (m_owed >= LIM) ? 2 : 1; m_left = WIN - 1; end
            end else if (m_mode == 1) begin
                if (m_left == 1) m_mode = 0;
                m_left--;
            end else begin
                if (m_left == 0) m_left = WIN - 1;
                else begin
                    if (m_left == 1 && m_owed == 0 && !tk) m_mode = 0;
                    m_left--;
                end
            end
            if (tk && !e_ref) m_owed = (m_owed == LIM + 1) ? m_owed : m_owed + 1;
            else if (e_ref && !tk) m_owed--;
            m_tmr = tk ? 0 : m_tmr + 1;
            cyc++;
        end
    end

    task automatic one_req(input bit w, input bit u);
        req_valid = 1'b1; req_write = w; req_urgent = u;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        check(cmd_valid && cmd_kind == (w ? 2'b01 : 2'b00), "R6 accepted command",
              cmd_kind, w ? 1 : 0);
        @(posedge clk); #1;
        req_valid = 1'b0; req_urgent = 1'b0;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R7 reset ready", req_ready, 1);
        check(cmd_valid == 1'b0, "R7 reset cmd_valid", cmd_valid, 0);
        check(err_overflow == 1'b0, "R7 reset err", err_overflow, 0);
        repeat (60) @(posedge clk);
        #1;
        check(first_ref == INTV, "R1 first refresh cycle", first_ref, INTV);
        one_req(1'b0, 1'b0);
        one_req(1'b1, 1'b0);
        one_req(1'b1, 1'b1);
        // continuous non-urgent stream across ticks
        req_valid = 1'b1; req_urgent = 1'b0; req_write = 1'b0;
        for (int i = 0; i < 120; i++) begin
            @(posedge clk); #1 req_write = ~req_write;
        end
        // continuous urgent stream: deferral then forced catch-up
        b2b = 0;
        req_urgent = 1'b1;
        repeat (220) @(posedge clk);
        #1;
        check(b2b >= 2, "R5 back-to-back refreshes", b2b, 2);
        // pseudo-random mix
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 400; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                req_valid = lf[0]; req_urgent = lf[1] & lf[2]; req_write = lf[3];
                @(posedge clk); #1;
            end
        end
        req_valid = 1'b0; req_urgent = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(gap_bad == 0, "R3 window spacing", gap_bad, 0);
        check(r1_err == 1'b1, "R8 overflow flagged", r1_err, 1);
        repeat (30) @(posedge clk);
        @(negedge clk);
        check(r1_err == 1'b1, "R8 overflow sticky", r1_err, 1);
        check(err_overflow == 1'b0, "R8 no overflow on u0", err_overflow, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule